// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is a 16-bit up/down timer that produces centre-aligned (phase-correct) pulse-width modulation on two compare channels, A and B. On every enabled timer tick the counter takes one step up or down. It climbs from zero to a ceiling value (TOP), turns, and descends back to zero (BOTTOM). Each channel compares the counter with its own threshold. Its output is cleared when the threshold is crossed on the way up and set when it is crossed on the way down. The result is a symmetric pulse whose high time scales with the threshold.

A mode input selects the ceiling. Three modes give a fixed ceiling of 8, 9 or 10 bits. A fourth takes the ceiling from a dedicated ceiling register, and a fifth takes it from the active channel-A threshold. Thresholds are written into pending registers and are copied to the active registers only when the counter turns at TOP, so a pulse already in progress is never torn. Four sticky event flags report the BOTTOM, TOP and match events, and each can be cleared by a one-cycle pulse.

The direction controller has two states, joined by two transitions:
- RISE moves to FALL on the turn-at-top transition.
- FALL moves to RISE on the turn-at-bottom transition.

Top module: `pwm_dual_slope`

## Requirements
- R1: `mode` selects TOP as follows: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the ceiling register (reset value 0xFFFF), and 4 gives the active channel-A threshold. Codes 5 to 7 behave as code 0.
- R2: After reset the counter is 0 in state RISE. On each cycle with `tick` high, one of three things happens:
  - In RISE, when the count is at or above TOP and is nonzero, the count steps down and the state becomes FALL.
  - In FALL at count 0, the count steps up and the state becomes RISE.
  - Otherwise the count steps once in the current direction.

  With `tick` low, nothing changes. TOP and 0 each last one tick, so the period is 2·TOP ticks.
- R3: Threshold writes land in a pending register. Each active threshold is loaded from its pending register only on the turn-at-top tick. A write made during a period has no effect on the outputs before the next TOP.
- R4: `ovf_flag` is set on the clock after a turn-at-bottom tick.
- R5: On the turn-at-top tick, `top_flag` is set in mode 3 and `cmp_a_flag` is set in mode 4.
- R6: A channel's match flag is set on the clock after a tick on which the count equals that channel's active threshold.
- R7: The output select `omode_x` works as follows. Value 2 drives the waveform directly and value 3 drives its inverse. Values 0 and 1 drive the pin low. On a match tick, the waveform goes low if the next step is upward and goes high if the next step is downward. Its reset value is high. In steady state the waveform is high for 2·C of every 2·TOP ticks, where C is the threshold.
- R8: A channel whose active threshold is above TOP never matches, and its pin stays constant.
- R9: In modes 0, 1, 2 and 5 to 7, a threshold write keeps only the bits within TOP and stores the bits above TOP as zero.
- R10: A flag's clear input drops that flag on the next clock. A set event in the same cycle takes priority over the clear.
- R11: Reset clears the count, all flags and all thresholds, and sets both waveforms high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer step enable |
| mode | input | 3 | TOP source select |
| wr_data | input | 16 | Write data for the ceiling and thresholds |
| wr_top | input | 1 | Write the ceiling register |
| wr_cmp_a | input | 1 | Write the pending channel-A threshold |
| wr_cmp_b | input | 1 | Write the pending channel-B threshold |
| omode_a | input | 2 | Channel-A output select |
| omode_b | input | 2 | Channel-B output select |
| clr_ovf | input | 1 | Clear `ovf_flag` |
| clr_top | input | 1 | Clear `top_flag` |
| clr_cmp_a | input | 1 | Clear `cmp_a_flag` |
| clr_cmp_b | input | 1 | Clear `cmp_b_flag` |
| count | output | 16 | Counter value |
| pwm_a | output | 1 | Channel-A PWM pin |
| pwm_b | output | 1 | Channel-B PWM pin |
| ovf_flag | output | 1 | BOTTOM event flag |
| top_flag | output | 1 | TOP event flag (mode 3) |
| cmp_a_flag | output | 1 | Channel-A match flag |
| cmp_b_flag | output | 1 | Channel-B match flag |

## Verification
Most results land one clock after the stimulus that causes them: a count step, a flag set or clear, and a waveform change after a match. The same holds for an active-threshold load at TOP, which first affects a match on the tick that follows. The output select is the exception, because it reaches the pins within the same cycle. To respect these delays, the bench drives inputs 1 ns after the rising edge and lets its reference model update on that edge from the same inputs. It then compares every output at the falling edge, so each expected value is read in exactly the cycle it is due. Directed checks measure period and duty over whole 2·TOP windows, and they test a mid-period threshold write at a count where the old and new thresholds would give different pins.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;
    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } slope_t;

    localparam logic [2:0] MD_8B   = 3'd0;
    localparam logic [2:0] MD_9B   = 3'd1;
    localparam logic [2:0] MD_10B  = 3'd2;
    localparam logic [2:0] MD_REG  = 3'd3;
    localparam logic [2:0] MD_CMPA = 3'd4;

    localparam logic [1:0] OM_NORM = 2'd2;
    localparam logic [1:0] OM_INV  = 2'd3;
endpackage

// File: rtl/pwm_ds_slope.sv
module pwm_ds_slope
    import pwm_ds_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt,
    output slope_t       slope,
    output logic         next_rise,
    output logic         at_top,
    output logic         at_bottom
);
    localparam logic [W-1:0] ONE = W'(1);

    slope_t       st_q, st_n;
    logic [W-1:0] cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RISE;
        else     st_q <= st_n;
    end

    // counter register
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_n;
    end

    // transitions: turn-at-top (RISE->FALL), turn-at-bottom (FALL->RISE)
    always_comb begin
        st_n      = st_q;
        cnt_n     = cnt;
        at_top    = 1'b0;
        at_bottom = 1'b0;
        unique case (st_q)
            ST_RISE: begin
                if (tick) begin
                    if (cnt >= top_val && cnt != '0) begin
                        st_n   = ST_FALL;
                        at_top = 1'b1;
                        cnt_n  = cnt - ONE;
                    end else begin
                        cnt_n  = cnt + ONE;
                    end
                end
            end
            ST_FALL: begin
                if (tick) begin
                    if (cnt == '0) begin
                        st_n      = ST_RISE;
                        at_bottom = 1'b1;
                        cnt_n     = cnt + ONE;
                    end else begin
                        cnt_n     = cnt - ONE;
                    end
                end
            end
        endcase
    end

    assign slope     = st_q;
    assign next_rise = (st_n == ST_RISE);
endmodule

// File: rtl/pwm_ds_chan.sv
module pwm_ds_chan
    import pwm_ds_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         load,
    input  logic [W-1:0] cnt,
    input  logic         next_rise,
    input  logic [1:0]   omode,
    output logic [W-1:0] act,
    output logic         match,
    output logic         pin
);
    logic [W-1:0] pend_q;
    logic         wf_q;

    // pending threshold and active copy taken at TOP
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act    <= '0;
        end else begin
            if (wr_en) pend_q <= wr_val;
            if (load)  act    <= pend_q;
        end
    end

    assign match = tick && (cnt == act);

    // waveform: low when the next step rises, high when it falls
    always_ff @(posedge clk) begin
        if (rst)        wf_q <= 1'b1;
        else if (match) wf_q <= ~next_rise;
    end

    always_comb begin
        unique case (omode)
            OM_NORM: pin = wf_q;
            OM_INV:  pin = ~wf_q;
            default: pin = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
    import pwm_ds_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [2:0]   mode,
    input  logic [W-1:0] wr_data,
    input  logic         wr_top,
    input  logic         wr_cmp_a,
    input  logic         wr_cmp_b,
    input  logic [1:0]   omode_a,
    input  logic [1:0]   omode_b,
    input  logic         clr_ovf,
    input  logic         clr_top,
    input  logic         clr_cmp_a,
    input  logic         clr_cmp_b,
    output logic [W-1:0] count,
    output logic         pwm_a,
    output logic         pwm_b,
    output logic         ovf_flag,
    output logic         top_flag,
    output logic         cmp_a_flag,
    output logic         cmp_b_flag
);
    localparam int NCH = 2;
    localparam logic [W-1:0] TOP8  = W'(32'h00FF);
    localparam logic [W-1:0] TOP9  = W'(32'h01FF);
    localparam logic [W-1:0] TOP10 = W'(32'h03FF);

    logic [W-1:0] top_reg, top_val, wr_mask;
    logic         fixed_top;
    logic         at_top, at_bottom, next_rise;
    slope_t       slope;

    logic [NCH-1:0]        wr_en_v, match_v, pin_v;
    logic [NCH-1:0][1:0]   om_v;
    logic [NCH-1:0][W-1:0] act_v;

    assign wr_en_v = {wr_cmp_b, wr_cmp_a};
    assign om_v[0] = omode_a;
    assign om_v[1] = omode_b;

    always_comb begin
        fixed_top = 1'b1;
        unique case (mode)
            MD_9B:   top_val = TOP9;
            MD_10B:  top_val = TOP10;
            MD_REG:  begin top_val = top_reg;  fixed_top = 1'b0; end
            MD_CMPA: begin top_val = act_v[0]; fixed_top = 1'b0; end
            default: top_val = TOP8;
        endcase
    end

    assign wr_mask = fixed_top ? top_val : '1;

    always_ff @(posedge clk) begin
        if (rst)         top_reg <= '1;
        else if (wr_top) top_reg <= wr_data;
    end

    pwm_ds_slope #(.W(W)) u_slope (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .top_val   (top_val),
        .cnt       (count),
        .slope     (slope),
        .next_rise (next_rise),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_ds_chan #(.W(W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .wr_en     (wr_en_v[c]),
            .wr_val    (wr_data & wr_mask),
            .load      (at_top),
            .cnt       (count),
            .next_rise (next_rise),
            .omode     (om_v[c]),
            .act       (act_v[c]),
            .match     (match_v[c]),
            .pin       (pin_v[c])
        );
    end

    assign pwm_a = pin_v[0];
    assign pwm_b = pin_v[1];

    // sticky flags: set wins over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag   <= 1'b0;
            top_flag   <= 1'b0;
            cmp_a_flag <= 1'b0;
            cmp_b_flag <= 1'b0;
        end else begin
            if (at_bottom)                             ovf_flag   <= 1'b1;
            else if (clr_ovf)                          ovf_flag   <= 1'b0;
            if (at_top && mode == MD_REG)              top_flag   <= 1'b1;
            else if (clr_top)                          top_flag   <= 1'b0;
            if (match_v[0] || (at_top && mode == MD_CMPA)) cmp_a_flag <= 1'b1;
            else if (clr_cmp_a)                        cmp_a_flag <= 1'b0;
            if (match_v[1])                            cmp_b_flag <= 1'b1;
            else if (clr_cmp_b)                        cmp_b_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_ds_chk.sv
module pwm_ds_chk
    import pwm_ds_pkg::*;
#(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic [W-1:0]        count,
    input slope_t              slope,
    input logic                at_top,
    input logic [1:0][W-1:0]   act,
    input logic                ovf_flag,
    input logic                clr_ovf,
    input logic [1:0]          omode_a,
    input logic [1:0]          omode_b,
    input logic                pwm_a,
    input logic                pwm_b
);
    // R2: every tick moves the count by exactly one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1));

    // R2: no tick, no movement
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R3: active thresholds change only after a TOP turn
    a_r3_load_at_top: assert property (@(posedge clk) disable iff (rst)
        !at_top |=> $stable(act));

    // R4: turning at BOTTOM raises the overflow flag
    a_r4_ovf_at_bottom: assert property (@(posedge clk) disable iff (rst)
        (tick && slope == ST_FALL && count == '0) |=> ovf_flag);

    // R7: disconnected output selects keep the pins low
    a_r7_off_a: assert property (@(posedge clk) disable iff (rst)
        !omode_a[1] |-> !pwm_a);
    a_r7_off_b: assert property (@(posedge clk) disable iff (rst)
        !omode_b[1] |-> !pwm_b);

    // R10: clear without a concurrent set drops the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_ovf && !(tick && slope == ST_FALL && count == '0)) |=> !ovf_flag);
endmodule

bind pwm_dual_slope pwm_ds_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .count    (count),
    .slope    (slope),
    .at_top   (at_top),
    .act      (act_v),
    .ovf_flag (ovf_flag),
    .clr_ovf  (clr_ovf),
    .omode_a  (omode_a),
    .omode_b  (omode_b),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b)
);

// File: tb/sim_pwm_dual_slope.sv
`timescale 1ns/1ps
module sim_pwm_dual_slope;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic [2:0]  mode = 3'd3;
    logic [15:0] wr_data = '0;
    logic        wr_top = 0, wr_cmp_a = 0, wr_cmp_b = 0;
    logic [1:0]  omode_a = 2'd2, omode_b = 2'd3;
    logic        clr_ovf = 0, clr_top = 0, clr_cmp_a = 0, clr_cmp_b = 0;
    logic [15:0] count;
    logic        pwm_a, pwm_b, ovf_flag, top_flag, cmp_a_flag, cmp_b_flag;

    always #2 clk = ~clk;

    pwm_dual_slope u0 (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode), .wr_data(wr_data),
        .wr_top(wr_top), .wr_cmp_a(wr_cmp_a), .wr_cmp_b(wr_cmp_b),
        .omode_a(omode_a), .omode_b(omode_b),
        .clr_ovf(clr_ovf), .clr_top(clr_top), .clr_cmp_a(clr_cmp_a), .clr_cmp_b(clr_cmp_b),
        .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .ovf_flag(ovf_flag),
        .top_flag(top_flag), .cmp_a_flag(cmp_a_flag), .cmp_b_flag(cmp_b_flag)
    );

    int  n_chk = 0, n_fail = 0;
    bit  live = 0, done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    int m_cnt, m_topr, m_tv, m_msk;
    bit m_fall, m_ovf, m_top, m_ca, m_cb, m_up_next, m_ev_top, m_ev_bot;
    int m_pend[2], m_act[2];
    bit m_wf[2], m_mt[2];

    function automatic int f_top();
        case (mode)
            3'd1: return 511;
            3'd2: return 1023;
            3'd3: return m_topr;
            3'd4: return m_act[0];
            default: return 255;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_fall = 0; m_topr = 65535;
            m_ovf = 0; m_top = 0; m_ca = 0; m_cb = 0;
            for (int c = 0; c < 2; c++) begin m_pend[c] = 0; m_act[c] = 0; m_wf[c] = 1; end
        end else begin
            m_tv  = f_top();
            m_msk = (mode == 3'd3 || mode == 3'd4) ? 65535 : m_tv;
            m_ev_top = 0; m_ev_bot = 0; m_mt[0] = 0; m_mt[1] = 0;
            if (tick) begin
                if (!m_fall && m_cnt >= m_tv && m_cnt != 0) m_ev_top = 1;
                if (m_fall && m_cnt == 0) m_ev_bot = 1;
                m_up_next = m_fall ? m_ev_bot : !m_ev_top;
                for (int c = 0; c < 2; c++) begin
                    m_mt[c] = (m_cnt == m_act[c]);
                    if (m_mt[c]) m_wf[c] = !m_up_next;
                end
                m_cnt  = m_up_next ? m_cnt + 1 : m_cnt - 1;
                m_fall = !m_up_next;
            end
            if (clr_ovf)   m_ovf = 0;
            if (clr_top)   m_top = 0;
            if (clr_cmp_a) m_ca = 0;
            if (clr_cmp_b) m_cb = 0;
            if (m_ev_bot) m_ovf = 1;
            if (m_ev_top && mode == 3'd3) m_top = 1;
            if (m_mt[0] || (m_ev_top && mode == 3'd4)) m_ca = 1;
            if (m_mt[1]) m_cb = 1;
            if (m_ev_top) begin m_act[0] = m_pend[0]; m_act[1] = m_pend[1]; end
            if (wr_top)   m_topr = int'(wr_data);
            if (wr_cmp_a) m_pend[0] = int'(wr_data) & m_msk;
            if (wr_cmp_b) m_pend[1] = int'(wr_data) & m_msk;
        end
    end

    function automatic bit exp_pin(input logic [1:0] om, input bit wf);
        return (om == 2'd2) ? wf : (om == 2'd3) ? !wf : 1'b0;
    endfunction

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (!rst && live) begin
            chk(int'(count) == m_cnt, "R2 count", int'(count), m_cnt);
            chk(pwm_a == exp_pin(omode_a, m_wf[0]), "R7 pwm_a", pwm_a, exp_pin(omode_a, m_wf[0]));
            chk(pwm_b == exp_pin(omode_b, m_wf[1]), "R7 pwm_b", pwm_b, exp_pin(omode_b, m_wf[1]));
            chk(ovf_flag == m_ovf, "R4/R10 ovf_flag", ovf_flag, m_ovf);
            chk(top_flag == m_top, "R5/R10 top_flag", top_flag, m_top);
            chk(cmp_a_flag == m_ca, "R6/R5 cmp_a_flag", cmp_a_flag, m_ca);
            chk(cmp_b_flag == m_cb, "R6 cmp_b_flag", cmp_b_flag, m_cb);
        end
    end

    // watchdog
    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(posedge clk); #1;
        wr_top = 0; wr_cmp_a = 0; wr_cmp_b = 0;
        clr_ovf = 0; clr_top = 0; clr_cmp_a = 0; clr_cmp_b = 0;
    endtask

    task automatic run(input int n);
        repeat (n) cyc();
    endtask

    int z1, z2, hi_a, hi_b, chg;
    bit first_b;

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(count == 0, "R11 count", count, 0);
        chk(pwm_a == 1, "R11 pwm_a waveform high", pwm_a, 1);
        chk(pwm_b == 0, "R11 pwm_b inverted", pwm_b, 0);
        chk({ovf_flag, top_flag, cmp_a_flag, cmp_b_flag} == 0, "R11 flags",
            {ovf_flag, top_flag, cmp_a_flag, cmp_b_flag}, 0);
        @(posedge clk); #1;
        rst = 0; live = 1;

        // R1 mode 3: ceiling register = 10, thresholds 4 and 7
        wr_data = 16'd10; wr_top = 1; cyc();
        wr_data = 16'd4;  wr_cmp_a = 1; cyc();
        wr_data = 16'd7;  wr_cmp_b = 1; cyc();
        run(40);

        // R2: period is 2*TOP
        z1 = -1; z2 = -1;
        for (int i = 0; i < 45; i++) begin
            cyc(); @(negedge clk);
            if (count == 0) begin
                if (z1 < 0) z1 = i;
                else if (z2 < 0) z2 = i;
            end
        end
        chk(z2 - z1 == 20, "R2 period", z2 - z1, 20);

        // R7: duty over one full period
        hi_a = 0; hi_b = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(); @(negedge clk);
            hi_a += pwm_a; hi_b += pwm_b;
        end
        chk(hi_a == 8, "R7 duty non-inverted", hi_a, 8);
        chk(hi_b == 6, "R7 duty inverted", hi_b, 6);

        // R3: write at BOTTOM, old threshold still governs this period
        do begin cyc(); @(negedge clk); end while (count != 0);
        wr_data = 16'd8; wr_cmp_a = 1; cyc();
        do begin cyc(); @(negedge clk); end while (count != 5);
        chk(pwm_a == 0, "R3 old threshold in force", pwm_a, 0);
        run(40);
        hi_a = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(); @(negedge clk);
            hi_a += pwm_a;
        end
        chk(hi_a == 16, "R3 new threshold after TOP", hi_a, 16);

        // R8: threshold above TOP never matches
        wr_data = 16'd20; wr_cmp_b = 1; cyc();
        run(25);
        clr_cmp_b = 1; cyc();
        @(negedge clk); first_b = pwm_b; chg = 0;
        for (int i = 0; i < 25; i++) begin
            cyc(); @(negedge clk);
            if (pwm_b != first_b) chg++;
        end
        chk(chg == 0, "R8 pin constant", chg, 0);
        chk(cmp_b_flag == 0, "R8 no match flag", cmp_b_flag, 0);

        // R2: sparse ticks
        for (int i = 0; i < 60; i++) begin
            tick = (i % 3 != 0); cyc();
        end
        tick = 1;

        // R10: clears, some colliding with set events
        for (int i = 0; i < 30; i++) begin
            clr_ovf = i[0]; clr_top = i[1]; clr_cmp_a = i[0]; clr_cmp_b = 1;
            @(posedge clk); #1;
        end
        cyc();

        // R1/R5 mode 4: TOP from channel-A threshold
        mode = 3'd4; omode_a = 2'd3; omode_b = 2'd2;
        wr_data = 16'd12; wr_cmp_a = 1; cyc();
        wr_data = 16'd5;  wr_cmp_b = 1; cyc();
        clr_cmp_a = 1; cyc();
        run(80);

        // R9: fixed 8-bit mode masks writes
        mode = 3'd0; omode_a = 2'd2; omode_b = 2'd3; cyc();
        wr_data = 16'h0180; wr_cmp_a = 1; cyc();
        wr_data = 16'h1234; wr_cmp_b = 1; cyc();
        run(600);
        hi_a = 0; hi_b = 0;
        for (int i = 0; i < 510; i++) begin
            cyc(); @(negedge clk);
            hi_a += pwm_a; hi_b += pwm_b;
        end
        chk(hi_a == 256, "R9 masked threshold A duty", hi_a, 256);
        chk(hi_b == 406, "R9 masked threshold B duty", hi_b, 406);

        // R1 modes 1 and 2, R7 disconnected selects
        mode = 3'd1; omode_a = 2'd1; cyc();
        run(1100);
        mode = 3'd2; omode_b = 2'd0; omode_a = 2'd2; cyc();
        run(2100);
        mode = 3'd6; omode_b = 2'd3; cyc();
        run(600);

        live = 0;
        report();
    end
endmodule